// File: doc/BRIEF.md
# Software/hardware shared register field

This block is one register field that is reachable from two sides at once. Software reaches it through a decoded access strobe that is already qualified by address, with a direction bit and write data. On-chip logic reaches it through a next-value bus. That bus is loaded under either an active-high or an active-low write enable, or is captured as sticky event bits. The field value is a register output. Next to it sit two single-cycle strobes: one marks that software touched the field and one marks that software changed it.

A parameter picks one of four behaviours. Plain mode is an ordinary read/write field. Pulse mode lets a written value live for exactly one cycle before it falls back to zero. Sticky-bit mode collects hardware event bits with an OR. Sticky-value mode captures the first non-zero hardware value and holds it. In both sticky modes software empties the field, and a second parameter chooses how: by reading it, or by writing ones over the bits to be cleared. The field takes every access and every hardware update in the cycle it arrives, so it has no valid/ready pair and never applies back-pressure. All pins are plain control and data.

Top module: `swhw_field`

## Requirements
- R1: While reset is asserted and after it is released, the field reads RESET_VAL (default 0) and both strobes are low until an access arrives.
- R2: `acc_pulse` is high in exactly the cycles in which `sw_req` is high, whether the access is a read or a write.
- R3: `mod_pulse` is high in the cycle of a software change: any write in plain or pulse mode, a read in sticky clear-on-read mode, a write in sticky write-one-to-clear mode. The changed value appears on `field_q` after the next rising edge. `mod_pulse` is never high without `acc_pulse`.
- R4: In plain and pulse modes, when `hw_we`=1 or `hw_we_n`=0 and software is not writing, `field_q` takes `hw_next` at the next edge. With `hw_we`=0 and `hw_we_n`=1, plain mode holds its value.
- R5: When a software write and a hardware write fall in the same cycle, the software data is stored and the hardware data is dropped.
- R6: In pulse mode a written value shows on `field_q` for exactly one cycle and then returns to zero unless it is written again.
- R7: In sticky-bit mode each `hw_next` bit at 1 sets that field bit at the next edge. The bit stays set after the input drops, until software clears it.
- R8: In sticky-value mode, while the field is zero, a non-zero `hw_next` is captured at the next edge. While the field is non-zero, `hw_next` is ignored.
- R9: In sticky clear-on-read mode (CLR=CLR_ON_READ), a read (`sw_req`=1, `sw_wr`=0) makes the field zero at the next edge. Hardware input in that same cycle is dropped, and capture resumes in the following cycle.
- R10: In sticky write-one-to-clear mode (CLR=CLR_ON_WRITE1), a write clears exactly the field bits whose `sw_wdata` bit is 1 and keeps the others. Hardware input in that cycle is dropped, and a read changes nothing.
- R11: In sticky clear-on-read mode a software write has no effect on the field and raises no `mod_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req | input | 1 | Decoded software access to this field |
| sw_wr | input | 1 | 1 = write, 0 = read (valid with sw_req) |
| sw_wdata | input | WIDTH | Software write data or clear mask |
| hw_next | input | WIDTH | Hardware next value or event bits |
| hw_we | input | 1 | Hardware write enable, active high |
| hw_we_n | input | 1 | Hardware write enable, active low |
| field_q | output | WIDTH | Current field value |
| acc_pulse | output | 1 | Software access strobe |
| mod_pulse | output | 1 | Software modify strobe |

## Verification
Two things can land in the same cycle: a software action and a hardware update. In plain mode that means a write and a load through either enable. In the sticky modes it means a clear and a fresh event. The bench drives both in one cycle and expects the software result after the edge: the written data, or a cleared field with no trace of the hardware bits. The cycle after that is checked as well, to see that capture works again.

// File: rtl/swhw_field_pkg.sv
package swhw_field_pkg;

  typedef enum logic [1:0] {
    FLD_PLAIN      = 2'd0,
    FLD_PULSE      = 2'd1,
    FLD_STICKY_BIT = 2'd2,
    FLD_STICKY_VAL = 2'd3
  } fld_mode_e;

  typedef enum logic {
    CLR_ON_READ   = 1'b0,
    CLR_ON_WRITE1 = 1'b1
  } fld_clr_e;

  function automatic logic mode_is_sticky(fld_mode_e m);
    return (m == FLD_STICKY_BIT) || (m == FLD_STICKY_VAL);
  endfunction

endpackage

// File: rtl/swf_sw_decode.sv
module swf_sw_decode
  import swhw_field_pkg::*;
#(
  parameter fld_mode_e MODE = FLD_PLAIN,
  parameter fld_clr_e  CLR  = CLR_ON_READ
) (
  input  logic sw_req,
  input  logic sw_wr,
  output logic acc,
  output logic sw_load,
  output logic sw_clr,
  output logic mod
);
  localparam logic STICKY = mode_is_sticky(MODE);

  always_comb begin
    acc     = sw_req;
    sw_load = 1'b0;
    sw_clr  = 1'b0;
    if (sw_req) begin
      if (STICKY) begin
        if (CLR == CLR_ON_READ) sw_clr = !sw_wr;
        else                    sw_clr = sw_wr;
      end else begin
        sw_load = sw_wr;
      end
    end
    mod = sw_load | sw_clr;
  end

endmodule

// File: rtl/swf_hw_path.sv
module swf_hw_path
  import swhw_field_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter fld_mode_e MODE  = FLD_PLAIN
) (
  input  logic [WIDTH-1:0] hw_next,
  input  logic             hw_we,
  input  logic             hw_we_n,
  input  logic [WIDTH-1:0] cur_q,
  output logic             hw_load,
  output logic [WIDTH-1:0] set_vec
);
  assign hw_load = hw_we | ~hw_we_n;

  generate
    if (MODE == FLD_STICKY_BIT) begin : g_bit
      assign set_vec = hw_next;
    end else if (MODE == FLD_STICKY_VAL) begin : g_val
      // capture only while empty; a held value locks out later inputs
      assign set_vec = (cur_q == '0) ? hw_next : '0;
    end else begin : g_none
      assign set_vec = '0;
    end
  endgenerate

endmodule

// File: rtl/swf_next_calc.sv
module swf_next_calc
  import swhw_field_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter fld_mode_e MODE  = FLD_PLAIN,
  parameter fld_clr_e  CLR  = CLR_ON_READ
) (
  input  logic [WIDTH-1:0] cur_q,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic             sw_load,
  input  logic             sw_clr,
  input  logic [WIDTH-1:0] hw_next,
  input  logic             hw_load,
  input  logic [WIDTH-1:0] set_vec,
  output logic [WIDTH-1:0] nxt_q
);
  logic [WIDTH-1:0] clr_result;

  generate
    if (CLR == CLR_ON_READ) begin : g_rclr
      assign clr_result = '0;
    end else begin : g_w1c
      assign clr_result = cur_q & ~sw_wdata;
    end
  endgenerate

  always_comb begin
    unique case (MODE)
      FLD_PLAIN: begin
        if (sw_load)      nxt_q = sw_wdata;
        else if (hw_load) nxt_q = hw_next;
        else              nxt_q = cur_q;
      end
      FLD_PULSE: begin
        if (sw_load)      nxt_q = sw_wdata;
        else if (hw_load) nxt_q = hw_next;
        else              nxt_q = '0;
      end
      default: begin
        // software clear wins the whole cycle
        if (sw_clr) nxt_q = clr_result;
        else        nxt_q = cur_q | set_vec;
      end
    endcase
  end

endmodule

// File: rtl/swhw_field.sv
module swhw_field
  import swhw_field_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter fld_mode_e        MODE      = FLD_PLAIN,
  parameter fld_clr_e         CLR       = CLR_ON_READ,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic             sw_wr,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic [WIDTH-1:0] hw_next,
  input  logic             hw_we,
  input  logic             hw_we_n,
  output logic [WIDTH-1:0] field_q,
  output logic             acc_pulse,
  output logic             mod_pulse
);
  logic             sw_load;
  logic             sw_clr;
  logic             hw_load;
  logic [WIDTH-1:0] set_vec;
  logic [WIDTH-1:0] nxt_q;

  swf_sw_decode #(.MODE(MODE), .CLR(CLR)) u_dec (
    .sw_req (sw_req),
    .sw_wr  (sw_wr),
    .acc    (acc_pulse),
    .sw_load(sw_load),
    .sw_clr (sw_clr),
    .mod    (mod_pulse)
  );

  swf_hw_path #(.WIDTH(WIDTH), .MODE(MODE)) u_hw (
    .hw_next(hw_next),
    .hw_we  (hw_we),
    .hw_we_n(hw_we_n),
    .cur_q  (field_q),
    .hw_load(hw_load),
    .set_vec(set_vec)
  );

  swf_next_calc #(.WIDTH(WIDTH), .MODE(MODE), .CLR(CLR)) u_nxt (
    .cur_q   (field_q),
    .sw_wdata(sw_wdata),
    .sw_load (sw_load),
    .sw_clr  (sw_clr),
    .hw_next (hw_next),
    .hw_load (hw_load),
    .set_vec (set_vec),
    .nxt_q   (nxt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= RESET_VAL;
    else        field_q <= nxt_q;
  end

endmodule

// File: rtl/swhw_field_chk.sv
module swhw_field_chk
  import swhw_field_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter fld_mode_e MODE  = FLD_PLAIN,
  parameter fld_clr_e  CLR   = CLR_ON_READ
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_req,
  input logic             sw_wr,
  input logic [WIDTH-1:0] sw_wdata,
  input logic [WIDTH-1:0] hw_next,
  input logic             hw_we,
  input logic             hw_we_n,
  input logic [WIDTH-1:0] field_q,
  input logic             acc_pulse,
  input logic             mod_pulse
);
  logic wr_hit;
  logic hw_en;
  logic clr_hit;
  assign wr_hit  = sw_req && sw_wr;
  assign hw_en   = hw_we || !hw_we_n;
  assign clr_hit = sw_req && ((CLR == CLR_ON_READ) ? !sw_wr : sw_wr);

  // R3
  mod_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_pulse |-> acc_pulse);

  generate
    if (MODE == FLD_PLAIN || MODE == FLD_PULSE) begin : g_rw
      // R4
      hw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && hw_en) |=> field_q == $past(hw_next));
      // R5
      sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> field_q == $past(sw_wdata));
    end
    if (MODE == FLD_PULSE) begin : g_pulse
      // R6
      pulse_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !hw_en) |=> field_q == '0);
    end
    if (MODE == FLD_STICKY_BIT) begin : g_sbit
      // R7
      sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> (field_q & $past(field_q)) == $past(field_q));
    end
    if (MODE == FLD_STICKY_VAL) begin : g_sval
      // R8
      sticky_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hit && field_q != '0) |=> $stable(field_q));
    end
    if (mode_is_sticky(MODE) && CLR == CLR_ON_READ) begin : g_rclr
      // R9
      read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> field_q == '0);
    end
    if (mode_is_sticky(MODE) && CLR == CLR_ON_WRITE1) begin : g_w1c
      // R10
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> field_q == ($past(field_q) & ~$past(sw_wdata)));
    end
  endgenerate

endmodule

bind swhw_field swhw_field_chk #(.WIDTH(WIDTH), .MODE(MODE), .CLR(CLR)) u_swhw_field_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sw_req   (sw_req),
  .sw_wr    (sw_wr),
  .sw_wdata (sw_wdata),
  .hw_next  (hw_next),
  .hw_we    (hw_we),
  .hw_we_n  (hw_we_n),
  .field_q  (field_q),
  .acc_pulse(acc_pulse),
  .mod_pulse(mod_pulse)
);

// File: tb/swhw_field_bench.sv
module swhw_field_bench;
  import swhw_field_pkg::*;

  localparam int W  = 8;
  localparam int NI = 5;

  typedef struct {
    int          inst;
    logic [W-1:0] q;
    logic        acc;
    logic        mod;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         req_a  [NI];
  logic         wr_a   [NI];
  logic [W-1:0] wd_a   [NI];
  logic [W-1:0] hn_a   [NI];
  logic         we_a   [NI];
  logic         wen_a  [NI];
  logic [W-1:0] q_a    [NI];
  logic         acc_a  [NI];
  logic         mod_a  [NI];

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  exp_t sb[$];

  swhw_field #(.WIDTH(W)) u_swhw_field (
    .clk(clk), .rst_n(rst_n), .sw_req(req_a[0]), .sw_wr(wr_a[0]), .sw_wdata(wd_a[0]),
    .hw_next(hn_a[0]), .hw_we(we_a[0]), .hw_we_n(wen_a[0]),
    .field_q(q_a[0]), .acc_pulse(acc_a[0]), .mod_pulse(mod_a[0]));

  swhw_field #(.WIDTH(W), .MODE(FLD_PULSE)) u_swhw_field_pulse (
    .clk(clk), .rst_n(rst_n), .sw_req(req_a[1]), .sw_wr(wr_a[1]), .sw_wdata(wd_a[1]),
    .hw_next(hn_a[1]), .hw_we(we_a[1]), .hw_we_n(wen_a[1]),
    .field_q(q_a[1]), .acc_pulse(acc_a[1]), .mod_pulse(mod_a[1]));

  swhw_field #(.WIDTH(W), .MODE(FLD_STICKY_BIT), .CLR(CLR_ON_READ)) u_swhw_field_sbit_rc (
    .clk(clk), .rst_n(rst_n), .sw_req(req_a[2]), .sw_wr(wr_a[2]), .sw_wdata(wd_a[2]),
    .hw_next(hn_a[2]), .hw_we(we_a[2]), .hw_we_n(wen_a[2]),
    .field_q(q_a[2]), .acc_pulse(acc_a[2]), .mod_pulse(mod_a[2]));

  swhw_field #(.WIDTH(W), .MODE(FLD_STICKY_VAL), .CLR(CLR_ON_WRITE1)) u_swhw_field_sval_w1c (
    .clk(clk), .rst_n(rst_n), .sw_req(req_a[3]), .sw_wr(wr_a[3]), .sw_wdata(wd_a[3]),
    .hw_next(hn_a[3]), .hw_we(we_a[3]), .hw_we_n(wen_a[3]),
    .field_q(q_a[3]), .acc_pulse(acc_a[3]), .mod_pulse(mod_a[3]));

  swhw_field #(.WIDTH(W), .MODE(FLD_STICKY_BIT), .CLR(CLR_ON_WRITE1)) u_swhw_field_sbit_w1c (
    .clk(clk), .rst_n(rst_n), .sw_req(req_a[4]), .sw_wr(wr_a[4]), .sw_wdata(wd_a[4]),
    .hw_next(hn_a[4]), .hw_we(we_a[4]), .hw_we_n(wen_a[4]),
    .field_q(q_a[4]), .acc_pulse(acc_a[4]), .mod_pulse(mod_a[4]));

  task automatic idle_all();
    for (int k = 0; k < NI; k++) begin
      req_a[k] = 1'b0; wr_a[k] = 1'b0; wd_a[k] = '0;
      hn_a[k]  = '0;   we_a[k] = 1'b0; wen_a[k] = 1'b1;
    end
  endtask

  // driver: one cycle of stimulus for instance i, expectation pushed to the scoreboard
  task automatic step(int i, logic req, logic wr, logic [W-1:0] wd, logic [W-1:0] hn,
                      logic we, logic wen, logic [W-1:0] eq, logic eacc, logic emod,
                      string tag);
    exp_t e;
    @(negedge clk);
    idle_all();
    req_a[i] = req; wr_a[i] = wr; wd_a[i] = wd;
    hn_a[i] = hn; we_a[i] = we; wen_a[i] = wen;
    #1;
    e.inst = i; e.q = eq; e.acc = eacc; e.mod = emod; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor: after each edge, compare the popped item with the outputs
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (q_a[e.inst] !== e.q || acc_a[e.inst] !== e.acc || mod_a[e.inst] !== e.mod) begin
          n_err++;
          $display("FAIL %s inst%0d: q=%h acc=%b mod=%b expected q=%h acc=%b mod=%b",
                   e.tag, e.inst, q_a[e.inst], acc_a[e.inst], mod_a[e.inst],
                   e.q, e.acc, e.mod);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    // R1: reset state of every variant
    for (int k = 0; k < NI; k++) begin
      n_chk++;
      if (q_a[k] !== '0 || acc_a[k] !== 1'b0 || mod_a[k] !== 1'b0) begin
        n_err++;
        $display("FAIL R1 inst%0d: q=%h acc=%b mod=%b expected q=00 acc=0 mod=0",
                 k, q_a[k], acc_a[k], mod_a[k]);
      end
    end
    rst_n = 1'b1;

    // plain field
    step(0, 0, 0, 8'h00, 8'h00, 0, 1, 8'h00, 0, 0, "R1 idle after reset");
    step(0, 0, 0, 8'h00, 8'h3C, 1, 1, 8'h3C, 0, 0, "R4 high enable");
    step(0, 0, 0, 8'h00, 8'h5A, 0, 0, 8'h5A, 0, 0, "R4 low enable");
    step(0, 0, 0, 8'h00, 8'hFF, 0, 1, 8'h5A, 0, 0, "R4 hold");
    step(0, 1, 0, 8'h77, 8'h00, 0, 1, 8'h5A, 1, 0, "R2 read strobe");
    step(0, 1, 1, 8'h11, 8'h99, 1, 0, 8'h11, 1, 1, "R5 sw over hw, R3");
    step(0, 0, 0, 8'h00, 8'h00, 0, 1, 8'h11, 0, 0, "R3 value kept");

    // pulse field
    step(1, 1, 1, 8'h01, 8'h00, 0, 1, 8'h01, 1, 1, "R6 write one");
    step(1, 0, 0, 8'h00, 8'h00, 0, 1, 8'h00, 0, 0, "R6 self clear");
    step(1, 0, 0, 8'h00, 8'h00, 0, 1, 8'h00, 0, 0, "R6 stays zero");
    step(1, 1, 1, 8'h81, 8'h00, 0, 1, 8'h81, 1, 1, "R6 write again");
    step(1, 1, 1, 8'h81, 8'h00, 0, 1, 8'h81, 1, 1, "R6 back to back");
    step(1, 0, 0, 8'h00, 8'h00, 0, 1, 8'h00, 0, 0, "R6 falls");

    // sticky bit, clear on read
    step(2, 0, 0, 8'h00, 8'h04, 0, 1, 8'h04, 0, 0, "R7 set");
    step(2, 0, 0, 8'h00, 8'h00, 0, 1, 8'h04, 0, 0, "R7 held");
    step(2, 0, 0, 8'h00, 8'h10, 0, 1, 8'h14, 0, 0, "R7 accumulate");
    step(2, 1, 1, 8'hFF, 8'h00, 0, 1, 8'h14, 1, 0, "R11 write ignored");
    step(2, 1, 0, 8'h00, 8'h01, 0, 1, 8'h00, 1, 1, "R9 read clears, hw dropped");
    step(2, 0, 0, 8'h00, 8'h01, 0, 1, 8'h01, 0, 0, "R9 rearmed");

    // sticky value, write one to clear
    step(3, 0, 0, 8'h00, 8'h00, 0, 1, 8'h00, 0, 0, "R8 zero input");
    step(3, 0, 0, 8'h00, 8'h21, 0, 1, 8'h21, 0, 0, "R8 capture");
    step(3, 0, 0, 8'h00, 8'h42, 0, 1, 8'h21, 0, 0, "R8 later ignored");
    step(3, 1, 0, 8'h00, 8'h00, 0, 1, 8'h21, 1, 0, "R10 read no effect");
    step(3, 1, 1, 8'h01, 8'h00, 0, 1, 8'h20, 1, 1, "R10 partial clear");
    step(3, 1, 1, 8'h20, 8'h07, 0, 1, 8'h00, 1, 1, "R10 clear, hw dropped");
    step(3, 0, 0, 8'h00, 8'h07, 0, 1, 8'h07, 0, 0, "R8 rearmed");

    // sticky bit, write one to clear
    step(4, 0, 0, 8'h00, 8'h0F, 0, 1, 8'h0F, 0, 0, "R7 set nibble");
    step(4, 1, 1, 8'h05, 8'h00, 0, 1, 8'h0A, 1, 1, "R10 masked clear");
    step(4, 0, 0, 8'h00, 8'h80, 0, 1, 8'h8A, 0, 0, "R7 add bit");

    step(0, 0, 0, 8'h00, 8'h00, 0, 1, 8'h11, 0, 0, "R4 final hold");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule